// File: doc/BRIEF.md
# Wishbone Width Up-Converter

This block joins a narrow Wishbone initiator port to a wider Wishbone target port. No clock passes through it and it holds no state. The target-side cycle, strobe and write-enable copy the initiator's. The target address drops the low initiator address bits that choose a byte lane group. On writes, initiator data appears on every lane of the wide bus. The byte selects land only in the lane that the address and the endianness parameter pick, and every other lane gets zero selects. On reads, the chosen lane of the wide read bus is returned to the initiator once the access is acknowledged.

Every response toward the initiator (acknowledge, retry, error and read data) is ORed with a matching daisy-chain input. Several such converters, or other devices, can then share one return path, because a device that is not addressed drives zeros. Single, block and read-modify-write accesses all pass through unchanged, since the block only re-maps lanes and adds no latency. The width ratio must be a power of two, and the default is an 8-bit initiator behind a 16-bit target.

Top module: `wb_upsizer`

## Requirements
- R1: `s_adr_o` equals `m_adr_i` with its low LANE_W bits removed, where LANE_W = log2(S_DW/M_DW). With the defaults, `s_adr_o = m_adr_i[15:1]`.
- R2: `s_cyc_o`, `s_stb_o` and `s_we_o` equal `m_cyc_i`, `m_stb_i` and `m_we_i` at all times.
- R3: Every M_DW-wide lane of `s_dat_o` carries `m_dat_i`, whatever the address.
- R4: With BIG_ENDIAN = 0, the lane index is `m_adr_i[LANE_W-1:0]`. Lane k occupies `s_dat_o[k*M_DW +: M_DW]` and `s_sel_o[k*M_DW/8 +: M_DW/8]`. That select group carries `m_sel_i` and all other select bits are 0.
- R5: With BIG_ENDIAN = 1, the lane index is RATIO-1 minus `m_adr_i[LANE_W-1:0]`, so address low bits 0 pick the highest lane. Select placement otherwise follows R4.
- R6: `m_dat_o` is the chosen lane of `s_dat_i` when `m_cyc_i`, `m_stb_i` and `s_ack_i` are all 1, and 0 otherwise. That value is bitwise ORed with `m_dat_chain_i`.
- R7: `m_ack_o` = (`s_ack_i` & `m_cyc_i` & `m_stb_i`) | `m_ack_chain_i`.
- R8: `m_rty_o` and `m_err_o` follow the rule of R7, using `s_rty_i`/`m_rty_chain_i` and `s_err_i`/`m_err_chain_i`.
- R9: Every output responds to an input change within the same clock period, with no register on any path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_cyc_i | input | 1 | Initiator cycle frame |
| m_stb_i | input | 1 | Initiator strobe |
| m_we_i | input | 1 | Initiator write enable |
| m_adr_i | input | M_AW | Initiator address |
| m_sel_i | input | M_DW/8 | Initiator byte selects |
| m_dat_i | input | M_DW | Initiator write data |
| m_dat_o | output | M_DW | Read data to initiator, chain-merged |
| m_ack_o | output | 1 | Acknowledge to initiator, chain-merged |
| m_rty_o | output | 1 | Retry to initiator, chain-merged |
| m_err_o | output | 1 | Error to initiator, chain-merged |
| m_ack_chain_i | input | 1 | Acknowledge from neighbouring devices |
| m_rty_chain_i | input | 1 | Retry from neighbouring devices |
| m_err_chain_i | input | 1 | Error from neighbouring devices |
| m_dat_chain_i | input | M_DW | Read data from neighbouring devices |
| s_cyc_o | output | 1 | Target cycle frame |
| s_stb_o | output | 1 | Target strobe |
| s_we_o | output | 1 | Target write enable |
| s_adr_o | output | M_AW-LANE_W | Target address |
| s_sel_o | output | S_DW/8 | Target byte selects |
| s_dat_o | output | S_DW | Target write data |
| s_dat_i | input | S_DW | Target read data |
| s_ack_i | input | 1 | Target acknowledge |
| s_rty_i | input | 1 | Target retry |
| s_err_i | input | 1 | Target error |

## Verification
The bound checker tests several invariants whenever an input changes:
- the control and address pass-through;
- the replication of write data on every lane;
- at most one active select lane, whose contents equal the initiator selects;
- the chain inputs forcing their outputs high;
- a quiet read bus when nothing acknowledges.

Which lane is chosen for each endianness, and the exact read-lane extraction, can only be shown by the bench. It drives one little-endian and one big-endian instance in parallel and compares both against a behavioural model. The bench also shows zero latency by changing an input in the middle of a period.

// File: rtl/wb_upsz_pkg.sv
package wb_upsz_pkg;
  localparam int RESP_N   = 3;
  localparam int RESP_ACK = 0;
  localparam int RESP_RTY = 1;
  localparam int RESP_ERR = 2;

  function automatic int lane_bits(input int m_dw, input int s_dw);
    return $clog2(s_dw / m_dw);
  endfunction
endpackage

// File: rtl/wb_upsz_lane_dec.sv
module wb_upsz_lane_dec #(
  parameter int M_AW       = 16,
  parameter int RATIO      = 2,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int LANE_W    = $clog2(RATIO)
) (
  input  logic [M_AW-1:0]        adr_i,
  output logic [RATIO-1:0]       lane_oh_o,
  output logic [M_AW-LANE_W-1:0] slv_adr_o
);
  logic [LANE_W-1:0] low;
  logic [LANE_W-1:0] idx;

  assign low       = adr_i[LANE_W-1:0];
  assign slv_adr_o = adr_i[M_AW-1:LANE_W];

  // RATIO is a power of two, so RATIO-1-low is the bitwise inverse
  generate
    if (BIG_ENDIAN) begin : g_be
      assign idx = ~low;
    end else begin : g_le
      assign idx = low;
    end
  endgenerate

  generate
    for (genvar g = 0; g < RATIO; g++) begin : g_oh
      assign lane_oh_o[g] = (idx == LANE_W'(g));
    end
  endgenerate
endmodule

// File: rtl/wb_upsz_wr_steer.sv
module wb_upsz_wr_steer #(
  parameter int M_DW  = 8,
  parameter int RATIO = 2,
  localparam int MSW  = M_DW / 8
) (
  input  logic [M_DW-1:0]        dat_i,
  input  logic [MSW-1:0]         sel_i,
  input  logic [RATIO-1:0]       lane_oh_i,
  output logic [RATIO*M_DW-1:0]  dat_o,
  output logic [RATIO*MSW-1:0]   sel_o
);
  generate
    for (genvar g = 0; g < RATIO; g++) begin : g_lane
      assign dat_o[g*M_DW +: M_DW] = dat_i;
      assign sel_o[g*MSW +: MSW]   = lane_oh_i[g] ? sel_i : '0;
    end
  endgenerate
endmodule

// File: rtl/wb_upsz_rd_merge.sv
module wb_upsz_rd_merge #(
  parameter int M_DW  = 8,
  parameter int RATIO = 2
) (
  input  logic [RATIO*M_DW-1:0] s_dat_i,
  input  logic [RATIO-1:0]      lane_oh_i,
  input  logic                  hit_i,
  input  logic [M_DW-1:0]       chain_i,
  output logic [M_DW-1:0]       dat_o
);
  logic [M_DW-1:0] part [RATIO];

  // AND-OR mux: one-hot lane keeps depth at log2(RATIO)+2
  generate
    for (genvar g = 0; g < RATIO; g++) begin : g_part
      assign part[g] = s_dat_i[g*M_DW +: M_DW] & {M_DW{lane_oh_i[g] & hit_i}};
    end
  endgenerate

  always_comb begin
    dat_o = chain_i;
    for (int k = 0; k < RATIO; k++) dat_o |= part[k];
  end
endmodule

// File: rtl/wb_upsz_resp_merge.sv
module wb_upsz_resp_merge
  import wb_upsz_pkg::*;
(
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic [RESP_N-1:0] slv_i,
  input  logic [RESP_N-1:0] chain_i,
  output logic [RESP_N-1:0] resp_o
);
  logic sel;
  assign sel = cyc_i & stb_i;

  generate
    for (genvar g = 0; g < RESP_N; g++) begin : g_resp
      assign resp_o[g] = (slv_i[g] & sel) | chain_i[g];
    end
  endgenerate
endmodule

// File: rtl/wb_upsizer.sv
module wb_upsizer
  import wb_upsz_pkg::*;
#(
  parameter int M_DW       = 8,
  parameter int S_DW       = 16,
  parameter int M_AW       = 16,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int RATIO     = S_DW / M_DW,
  localparam int LANE_W    = $clog2(RATIO),
  localparam int MSW       = M_DW / 8,
  localparam int SSW       = S_DW / 8,
  localparam int S_AW      = M_AW - LANE_W
) (
  input  logic            m_cyc_i,
  input  logic            m_stb_i,
  input  logic            m_we_i,
  input  logic [M_AW-1:0] m_adr_i,
  input  logic [MSW-1:0]  m_sel_i,
  input  logic [M_DW-1:0] m_dat_i,
  output logic [M_DW-1:0] m_dat_o,
  output logic            m_ack_o,
  output logic            m_rty_o,
  output logic            m_err_o,
  input  logic            m_ack_chain_i,
  input  logic            m_rty_chain_i,
  input  logic            m_err_chain_i,
  input  logic [M_DW-1:0] m_dat_chain_i,
  output logic            s_cyc_o,
  output logic            s_stb_o,
  output logic            s_we_o,
  output logic [S_AW-1:0] s_adr_o,
  output logic [SSW-1:0]  s_sel_o,
  output logic [S_DW-1:0] s_dat_o,
  input  logic [S_DW-1:0] s_dat_i,
  input  logic            s_ack_i,
  input  logic            s_rty_i,
  input  logic            s_err_i
);
  logic [RATIO-1:0]  lane_oh;
  logic [RESP_N-1:0] slv_resp;
  logic [RESP_N-1:0] chain_resp;
  logic [RESP_N-1:0] m_resp;

  assign s_cyc_o = m_cyc_i;
  assign s_stb_o = m_stb_i;
  assign s_we_o  = m_we_i;

  wb_upsz_lane_dec #(
    .M_AW(M_AW), .RATIO(RATIO), .BIG_ENDIAN(BIG_ENDIAN)
  ) u_lane_dec (
    .adr_i(m_adr_i), .lane_oh_o(lane_oh), .slv_adr_o(s_adr_o)
  );

  wb_upsz_wr_steer #(
    .M_DW(M_DW), .RATIO(RATIO)
  ) u_wr_steer (
    .dat_i(m_dat_i), .sel_i(m_sel_i), .lane_oh_i(lane_oh),
    .dat_o(s_dat_o), .sel_o(s_sel_o)
  );

  wb_upsz_rd_merge #(
    .M_DW(M_DW), .RATIO(RATIO)
  ) u_rd_merge (
    .s_dat_i(s_dat_i), .lane_oh_i(lane_oh),
    .hit_i(m_cyc_i & m_stb_i & s_ack_i),
    .chain_i(m_dat_chain_i), .dat_o(m_dat_o)
  );

  assign slv_resp[RESP_ACK]   = s_ack_i;
  assign slv_resp[RESP_RTY]   = s_rty_i;
  assign slv_resp[RESP_ERR]   = s_err_i;
  assign chain_resp[RESP_ACK] = m_ack_chain_i;
  assign chain_resp[RESP_RTY] = m_rty_chain_i;
  assign chain_resp[RESP_ERR] = m_err_chain_i;

  wb_upsz_resp_merge u_resp_merge (
    .cyc_i(m_cyc_i), .stb_i(m_stb_i),
    .slv_i(slv_resp), .chain_i(chain_resp), .resp_o(m_resp)
  );

  assign m_ack_o = m_resp[RESP_ACK];
  assign m_rty_o = m_resp[RESP_RTY];
  assign m_err_o = m_resp[RESP_ERR];
endmodule

// File: rtl/wb_upsizer_chk.sv
module wb_upsizer_chk #(
  parameter int M_DW   = 8,
  parameter int S_DW   = 16,
  parameter int M_AW   = 16,
  localparam int RATIO = S_DW / M_DW,
  localparam int LANE_W = $clog2(RATIO),
  localparam int MSW   = M_DW / 8,
  localparam int SSW   = S_DW / 8
) (
  input logic                  m_cyc_i,
  input logic                  m_stb_i,
  input logic                  m_we_i,
  input logic [M_AW-1:0]       m_adr_i,
  input logic [MSW-1:0]        m_sel_i,
  input logic [M_DW-1:0]       m_dat_i,
  input logic [M_DW-1:0]       m_dat_o,
  input logic                  m_ack_o,
  input logic                  m_rty_o,
  input logic                  m_err_o,
  input logic                  m_ack_chain_i,
  input logic                  m_rty_chain_i,
  input logic                  m_err_chain_i,
  input logic [M_DW-1:0]       m_dat_chain_i,
  input logic                  s_cyc_o,
  input logic                  s_stb_o,
  input logic                  s_we_o,
  input logic [M_AW-LANE_W-1:0] s_adr_o,
  input logic [SSW-1:0]        s_sel_o,
  input logic [S_DW-1:0]       s_dat_o,
  input logic                  s_ack_i,
  input logic                  s_rty_i,
  input logic                  s_err_i
);
  logic [RATIO-1:0] lane_act;
  logic [MSW-1:0]   sel_or;
  logic             repl_ok;

  always_comb begin
    sel_or  = '0;
    repl_ok = 1'b1;
    for (int g = 0; g < RATIO; g++) begin
      lane_act[g] = |s_sel_o[g*MSW +: MSW];
      sel_or     |= s_sel_o[g*MSW +: MSW];
      if (s_dat_o[g*M_DW +: M_DW] != m_dat_i) repl_ok = 1'b0;
    end
  end

  always_comb begin
    a_r1_adr_shift: assert (s_adr_o == m_adr_i[M_AW-1:LANE_W]) else $error("R1 address");
    a_r2_ctrl_pass: assert (s_cyc_o == m_cyc_i && s_stb_o == m_stb_i && s_we_o == m_we_i)
      else $error("R2 control");
    a_r3_wdat_repl: assert (repl_ok) else $error("R3 replication");
    a_r4_one_lane: assert ($onehot0(lane_act)) else $error("R4 lanes");
    a_r4_sel_kept: assert (sel_or == m_sel_i) else $error("R4 selects");
    a_r6_rdat_quiet: assert (!(s_ack_i == 1'b0 && m_dat_chain_i == '0) || m_dat_o == '0)
      else $error("R6 quiet");
    a_r6_rdat_chain: assert ((m_dat_o & m_dat_chain_i) == m_dat_chain_i) else $error("R6 chain");
    a_r7_ack_chain: assert (!m_ack_chain_i || m_ack_o) else $error("R7 chain");
    a_r7_ack_idle: assert (m_ack_chain_i || m_cyc_i || !m_ack_o) else $error("R7 idle");
    a_r8_rty_chain: assert (!m_rty_chain_i || m_rty_o) else $error("R8 rty");
    a_r8_err_chain: assert (!m_err_chain_i || m_err_o) else $error("R8 err");
    a_r8_quiet: assert (s_rty_i || s_err_i || m_rty_chain_i || m_err_chain_i || (!m_rty_o && !m_err_o))
      else $error("R8 quiet");
  end
endmodule

bind wb_upsizer wb_upsizer_chk #(.M_DW(M_DW), .S_DW(S_DW), .M_AW(M_AW)) u_chk (
  .m_cyc_i(m_cyc_i), .m_stb_i(m_stb_i), .m_we_i(m_we_i), .m_adr_i(m_adr_i),
  .m_sel_i(m_sel_i), .m_dat_i(m_dat_i), .m_dat_o(m_dat_o), .m_ack_o(m_ack_o),
  .m_rty_o(m_rty_o), .m_err_o(m_err_o), .m_ack_chain_i(m_ack_chain_i),
  .m_rty_chain_i(m_rty_chain_i), .m_err_chain_i(m_err_chain_i),
  .m_dat_chain_i(m_dat_chain_i), .s_cyc_o(s_cyc_o), .s_stb_o(s_stb_o),
  .s_we_o(s_we_o), .s_adr_o(s_adr_o), .s_sel_o(s_sel_o), .s_dat_o(s_dat_o),
  .s_ack_i(s_ack_i), .s_rty_i(s_rty_i), .s_err_i(s_err_i)
);

// File: tb/wb_upsizer_bench.sv
module wb_upsizer_bench;
  localparam int M_DW = 8;
  localparam int S_DW = 16;
  localparam int M_AW = 16;
  localparam int RATIO = S_DW / M_DW;
  localparam int MSW = M_DW / 8;
  localparam int SSW = S_DW / 8;
  localparam int S_AW = M_AW - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic m_cyc, m_stb, m_we, ack_ch, rty_ch, err_ch, s_ack, s_rty, s_err;
  logic [M_AW-1:0] m_adr;
  logic [MSW-1:0]  m_sel;
  logic [M_DW-1:0] m_dat, dat_ch;
  logic [S_DW-1:0] s_rdat;

  logic [M_DW-1:0] le_mdat, be_mdat;
  logic le_ack, le_rty, le_err, be_ack, be_rty, be_err;
  logic le_cyc, le_stb, le_we, be_cyc, be_stb, be_we;
  logic [S_AW-1:0] le_adr, be_adr;
  logic [SSW-1:0]  le_sel, be_sel;
  logic [S_DW-1:0] le_sdat, be_sdat;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  wb_upsizer #(.M_DW(M_DW), .S_DW(S_DW), .M_AW(M_AW), .BIG_ENDIAN(1'b0)) u_wb_upsizer (
    .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_adr_i(m_adr), .m_sel_i(m_sel),
    .m_dat_i(m_dat), .m_dat_o(le_mdat), .m_ack_o(le_ack), .m_rty_o(le_rty), .m_err_o(le_err),
    .m_ack_chain_i(ack_ch), .m_rty_chain_i(rty_ch), .m_err_chain_i(err_ch),
    .m_dat_chain_i(dat_ch), .s_cyc_o(le_cyc), .s_stb_o(le_stb), .s_we_o(le_we),
    .s_adr_o(le_adr), .s_sel_o(le_sel), .s_dat_o(le_sdat), .s_dat_i(s_rdat),
    .s_ack_i(s_ack), .s_rty_i(s_rty), .s_err_i(s_err)
  );

  wb_upsizer #(.M_DW(M_DW), .S_DW(S_DW), .M_AW(M_AW), .BIG_ENDIAN(1'b1)) u_wb_upsizer_be (
    .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_adr_i(m_adr), .m_sel_i(m_sel),
    .m_dat_i(m_dat), .m_dat_o(be_mdat), .m_ack_o(be_ack), .m_rty_o(be_rty), .m_err_o(be_err),
    .m_ack_chain_i(ack_ch), .m_rty_chain_i(rty_ch), .m_err_chain_i(err_ch),
    .m_dat_chain_i(dat_ch), .s_cyc_o(be_cyc), .s_stb_o(be_stb), .s_we_o(be_we),
    .s_adr_o(be_adr), .s_sel_o(be_sel), .s_dat_o(be_sdat), .s_dat_i(s_rdat),
    .s_ack_i(s_ack), .s_rty_i(s_rty), .s_err_i(s_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference for one endianness
  task automatic compare(input bit big);
    int low, lane, hit;
    logic [S_DW-1:0] e_sel, e_sdat;
    logic [M_DW-1:0] e_mdat;
    low  = int'(m_adr) % RATIO;
    lane = big ? (RATIO - 1 - low) : low;
    hit  = (m_cyc && m_stb && s_ack) ? 1 : 0;
    e_sel = '0;
    e_sdat = '0;
    for (int k = 0; k < RATIO; k++) e_sdat = (e_sdat << M_DW) | S_DW'(m_dat);
    e_sel = SSW'(m_sel) << (lane * MSW);
    e_mdat = hit ? M_DW'(s_rdat >> (lane * M_DW)) : '0;
    e_mdat = e_mdat | dat_ch;
    if (!big) begin
      chk("R1 adr le", 64'(le_adr), 64'(int'(m_adr) / RATIO));
      chk("R2 ctrl le", {le_cyc, le_stb, le_we}, {m_cyc, m_stb, m_we});
      chk("R3 wdat le", 64'(le_sdat), 64'(e_sdat));
      chk("R4 sel le", 64'(le_sel), 64'(e_sel));
      chk("R6 rdat le", 64'(le_mdat), 64'(e_mdat));
      chk("R7 ack le", 64'(le_ack), 64'((s_ack && m_cyc && m_stb) || ack_ch));
      chk("R8 rty/err le", {le_rty, le_err},
          {((s_rty && m_cyc && m_stb) || rty_ch), ((s_err && m_cyc && m_stb) || err_ch)});
    end else begin
      chk("R1 adr be", 64'(be_adr), 64'(int'(m_adr) / RATIO));
      chk("R2 ctrl be", {be_cyc, be_stb, be_we}, {m_cyc, m_stb, m_we});
      chk("R3 wdat be", 64'(be_sdat), 64'(e_sdat));
      chk("R5 sel be", 64'(be_sel), 64'(e_sel));
      chk("R6 rdat be", 64'(be_mdat), 64'(e_mdat));
      chk("R7 ack be", 64'(be_ack), 64'((s_ack && m_cyc && m_stb) || ack_ch));
      chk("R8 rty/err be", {be_rty, be_err},
          {((s_rty && m_cyc && m_stb) || rty_ch), ((s_err && m_cyc && m_stb) || err_ch)});
    end
  endtask

  task automatic idle();
    {m_cyc, m_stb, m_we, ack_ch, rty_ch, err_ch, s_ack, s_rty, s_err} = '0;
    m_adr = '0; m_sel = '0; m_dat = '0; dat_ch = '0; s_rdat = '0;
  endtask

  // drive just after the rising edge, compare on the falling edge
  task automatic step();
    @(negedge clk);
    compare(1'b0);
    compare(1'b1);
    @(posedge clk);
    #2;
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    #2;
    @(negedge clk);
    chk("R7 reset idle ack", 64'({le_ack, be_ack, le_rty, le_err}), 64'(0));
    chk("R6 reset idle rdat", 64'({le_mdat, be_mdat}), 64'(0));
    chk("R4 reset idle sel", 64'({le_sel, be_sel}), 64'(0));
    @(posedge clk); #2;

    // R4/R5 write to both lanes, sel all ones
    m_cyc = 1; m_stb = 1; m_we = 1; m_sel = '1; m_dat = 8'hA5; m_adr = 16'h1230; step();
    m_adr = 16'h1231; step();
    @(negedge clk);
    chk("R5 odd addr picks low lane be", 64'(be_sel), 64'(2'b01));
    chk("R4 odd addr picks high lane le", 64'(le_sel), 64'(2'b10));
    @(posedge clk); #2;

    // R6 read, both lanes, ack high
    m_we = 0; s_rdat = 16'hBEEF; s_ack = 1; m_adr = 16'h0000; step();
    @(negedge clk);
    chk("R6 le lane0 read", 64'(le_mdat), 64'(8'hEF));
    chk("R6 be lane0 read", 64'(be_mdat), 64'(8'hBE));
    @(posedge clk); #2;
    m_adr = 16'h0001; step();

    // R6 ack without strobe: no data, no ack; chain still shows
    m_stb = 0; dat_ch = 8'h0C; ack_ch = 1; step();
    m_stb = 1; s_ack = 0; ack_ch = 0; dat_ch = 8'h30; step();

    // R9 same-period response
    s_ack = 0; s_err = 0; #3;
    chk("R9 before ack", 64'(le_ack), 64'(0));
    s_ack = 1; #1;
    chk("R9 ack within period", 64'(le_ack), 64'(1));
    s_err = 1; #1;
    chk("R9 err within period", 64'({le_err, be_err}), 64'(2'b11));
    step();
    idle(); m_cyc = 1; rty_ch = 1; err_ch = 1; step();

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      {m_cyc, m_stb, m_we, ack_ch, rty_ch, err_ch, s_ack, s_rty, s_err} = 9'($urandom);
      if ($urandom_range(0, 3) != 0) {ack_ch, rty_ch, err_ch} = '0;
      m_adr  = M_AW'($urandom);
      m_sel  = MSW'($urandom);
      m_dat  = M_DW'($urandom);
      s_rdat = S_DW'($urandom);
      dat_ch = ($urandom_range(0, 3) == 0) ? M_DW'($urandom) : '0;
      step();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule